// File: doc/BRIEF.md
# Quad DAC serial command decoder

This block is the digital front end of a four-channel 12-bit digital-to-analog converter. A host shifts 16-bit command words in over a three-wire SPI-style link: serial clock, serial data and an active-low frame select. The block brings these three asynchronous lines into the system clock domain and assembles each complete word. It then decodes a load mode and a channel address from the word and updates a double-buffered register pair (an input register and a DAC register) for each of channels A to D.

Each command picks its own load mode. A command can stage data in one channel's input register, write one channel's input and DAC registers together, move every staged input register into its DAC register at once, or write the same code into every channel. The four DAC register values leave the block as a flat bus for the converter cores. A one-cycle strobe per channel marks every DAC register write. An incomplete frame changes nothing. Reset clears every register to code zero.

Top module: `qdac_serial_dec`

## Requirements
- R1: A frame opens on a falling edge of `sync_ni`. While it stays low, `sdi_i` is sampled on each falling edge of `sclk_i`, most significant bit first. The word is acted on once exactly 16 bits have been taken. Word bits [15:14] are the load mode, bits [13:12] the channel address, and bits [11:0] the unsigned data code.
- R2: Load mode 2'b00 writes the data into the addressed channel's input register only. No DAC register and no strobe changes.
- R3: Load mode 2'b01 writes the data into both the input register and the DAC register of the addressed channel. It pulses that channel's strobe and no other.
- R4: Load mode 2'b10 copies every channel's input register into its DAC register and pulses all four strobes. The data field and channel address of the word are ignored.
- R5: Load mode 2'b11 writes the data into the input and DAC registers of all four channels and pulses all four strobes.
- R6: Reset (`rst_ni` low) clears all input and DAC registers to zero and holds every strobe low.
- R7: If `sync_ni` rises before the 16th bit, the frame is dropped and no register or strobe changes.
- R8: Serial clock edges after the 16th bit in the same frame are ignored. A further command needs a new falling edge of `sync_ni`.
- R9: A strobe is high for exactly one `clk_i` cycle per DAC register write. A channel's DAC value is constant in every cycle its strobe is low.
- R10: Channel address 2'b00, 2'b01, 2'b10 and 2'b11 select A, B, C and D. Channel k (A=0) drives `dac_o[12*k+11:12*k]` and `upd_o[k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous to clk_i |
| sdi_i | input | 1 | Serial data, sampled on sclk_i falling edge |
| sync_ni | input | 1 | Active-low frame select |
| dac_o | output | 48 | DAC register codes, channel A in the low 12 bits |
| upd_o | output | 4 | Per-channel DAC register write strobe |

## Verification
The bound checker watches the decoded word and the outputs on every cycle. It checks that a single-channel write strobes exactly the addressed channel, that a staging-only write strobes nothing, and that both broadcast modes strobe all channels. It also checks that a broadcast write lands the same code on every channel, that strobes last one cycle, and that no DAC value moves without its strobe. The serial framing can only be shown by the bench's scenarios: bit order, dropped short frames, ignored trailing bits and the contents of the staged input registers revealed through a later copy.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int unsigned DATA_W = 12;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned MODE_W = 2;
  localparam int unsigned NUM_CH = 1 << SEL_W;
  localparam int unsigned WORD_W = MODE_W + SEL_W + DATA_W;

  typedef enum logic [MODE_W-1:0] {
    LD_IN   = 2'b00,
    LD_BOTH = 2'b01,
    LD_COPY = 2'b10,
    LD_ALL  = 2'b11
  } ld_mode_e;

  typedef struct packed {
    ld_mode_e             mode;
    logic [SEL_W-1:0]     chan;
    logic [DATA_W-1:0]    data;
  } cmd_t;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/qdac_rx.sv
module qdac_rx
  import qdac_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sclk_i,
  input  logic  sdi_i,
  input  logic  sync_ni,
  output logic  vld_o,
  output cmd_t  cmd_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  // bit order: {sync, sclk, sdi}; idle lines reset high
  logic [2:0] raw, syn;
  assign raw = {sync_ni, sclk_i, sdi_i};

  qdac_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  logic sync_s, sclk_s, sdi_s;
  assign {sync_s, sclk_s, sdi_s} = syn;

  logic sync_d, sclk_d;
  logic sync_fall, sclk_fall;
  logic active_q, vld_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_d <= 1'b1;
      sclk_d <= 1'b1;
    end else begin
      sync_d <= sync_s;
      sclk_d <= sclk_s;
    end
  end

  assign sync_fall = sync_d & ~sync_s;
  assign sclk_fall = sclk_d & ~sclk_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      vld_q    <= 1'b0;
      cnt_q    <= '0;
      shift_q  <= '0;
    end else begin
      vld_q <= 1'b0;
      if (sync_fall) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (sync_s) begin
        // frame closed: a partial word is dropped
        active_q <= 1'b0;
      end else if (active_q && sclk_fall) begin
        shift_q <= {shift_q[WORD_W-2:0], sdi_s};
        if (cnt_q == LAST_BIT) begin
          vld_q    <= 1'b1;
          active_q <= 1'b0;
        end
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign vld_o = vld_q;
  assign cmd_o = cmd_t'(shift_q);
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
  import qdac_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  cmd_t                     cmd_i,
  output logic [NUM_CH*DATA_W-1:0] dac_o,
  output logic [NUM_CH-1:0]        upd_o
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic [DATA_W-1:0] in_q, dac_q;
    logic              upd_q, hit;

    assign hit = (cmd_i.chan == SEL_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_q  <= '0;
        dac_q <= '0;
        upd_q <= 1'b0;
      end else begin
        upd_q <= 1'b0;
        if (vld_i) begin
          unique case (cmd_i.mode)
            LD_IN: begin
              if (hit) in_q <= cmd_i.data;
            end
            LD_BOTH: begin
              if (hit) begin
                in_q  <= cmd_i.data;
                dac_q <= cmd_i.data;
                upd_q <= 1'b1;
              end
            end
            LD_COPY: begin
              dac_q <= in_q;
              upd_q <= 1'b1;
            end
            LD_ALL: begin
              in_q  <= cmd_i.data;
              dac_q <= cmd_i.data;
              upd_q <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end

    assign dac_o[k*DATA_W +: DATA_W] = dac_q;
    assign upd_o[k]                  = upd_q;
  end
endmodule

// File: rtl/qdac_serial_dec.sv
module qdac_serial_dec
  import qdac_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclk_i,
  input  logic                     sdi_i,
  input  logic                     sync_ni,
  output logic [NUM_CH*DATA_W-1:0] dac_o,
  output logic [NUM_CH-1:0]        upd_o
);
  logic word_vld;
  cmd_t word_cmd;

  qdac_rx #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .sdi_i  (sdi_i),
    .sync_ni(sync_ni),
    .vld_o  (word_vld),
    .cmd_o  (word_cmd)
  );

  qdac_bank u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (word_vld),
    .cmd_i (word_cmd),
    .dac_o (dac_o),
    .upd_o (upd_o)
  );
endmodule

// File: rtl/qdac_serial_dec_chk.sv
module qdac_serial_dec_chk
  import qdac_pkg::*;
(
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     vld_i,
  input cmd_t                     cmd_i,
  input logic [NUM_CH*DATA_W-1:0] dac_i,
  input logic [NUM_CH-1:0]        upd_i
);
  p_stage_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && cmd_i.mode == LD_IN |=> upd_i == '0);

  p_single_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && cmd_i.mode == LD_BOTH |=> upd_i == (NUM_CH'(1) << $past(cmd_i.chan)));

  p_copy_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && cmd_i.mode == LD_COPY |=> upd_i == '1);

  p_bcast_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && cmd_i.mode == LD_ALL |=> upd_i == '1 && dac_i == {NUM_CH{$past(cmd_i.data)}});

  p_no_spurious_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i != '0 |-> $past(vld_i));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    p_pulse_width_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_i[k] |=> !upd_i[k]);

    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !upd_i[k] |-> $stable(dac_i[k*DATA_W +: DATA_W]));
  end
endmodule

bind qdac_serial_dec qdac_serial_dec_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .vld_i (word_vld),
  .cmd_i (word_cmd),
  .dac_i (dac_o),
  .upd_i (upd_o)
);

// File: tb/qdac_serial_dec_bench.sv
module qdac_serial_dec_bench;
  localparam int DW   = 12;
  localparam int NCH  = 4;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sdi = 1'b0, sync_n = 1'b1;
  logic [NCH*DW-1:0] dac;
  logic [NCH-1:0]    upd;

  always #2 clk = ~clk;

  qdac_serial_dec u_qdac_serial_dec (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi),
    .sync_ni(sync_n), .dac_o(dac), .upd_o(upd)
  );

  int vectors = 0, miscompares = 0;
  int upd_cnt [NCH];
  int exp_cnt [NCH];
  logic [DW-1:0] in_m [NCH];
  logic [DW-1:0] dac_m[NCH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCH; k++) upd_cnt[k] <= 0;
    end else begin
      for (int k = 0; k < NCH; k++) if (upd[k]) upd_cnt[k] <= upd_cnt[k] + 1;
    end
  end

  task automatic model(input logic [15:0] w);
    for (int k = 0; k < NCH; k++) begin
      case (w[15:14])
        2'b00: if (w[13:12] == k) in_m[k] = w[11:0];
        2'b01: if (w[13:12] == k) begin in_m[k] = w[11:0]; dac_m[k] = w[11:0]; exp_cnt[k]++; end
        2'b10: begin dac_m[k] = in_m[k]; exp_cnt[k]++; end
        default: begin in_m[k] = w[11:0]; dac_m[k] = w[11:0]; exp_cnt[k]++; end
      endcase
    end
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    sync_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (HALF) @(negedge clk);
    sync_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w);
    send_bits({16'h0, w}, 16);
    model(w);
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < NCH; k++) begin
      vectors++;
      if (dac[k*DW +: DW] !== dac_m[k]) begin
        miscompares++;
        $display("FAIL %s ch%0d dac actual=%h expected=%h", req, k, dac[k*DW +: DW], dac_m[k]);
      end
      vectors++;
      if (upd_cnt[k] != exp_cnt[k]) begin
        miscompares++;
        $display("FAIL %s ch%0d strobes actual=%0d expected=%0d", req, k, upd_cnt[k], exp_cnt[k]);
      end
    end
  endtask

  task automatic t_reset;
    vectors++;
    if (dac !== '0 || upd !== '0) begin
      miscompares++;
      $display("FAIL R6 reset outputs actual=%h/%b expected=0/0", dac, upd);
    end
    check_all("R6");
    send_word(16'h8ABC);          // copy: input regs must hold zero
    check_all("R4 R6 copy after reset");
  endtask

  task automatic t_stage;
    send_word(16'h1123);          // mode 00, ch B
    check_all("R2 stage only");
    send_word(16'h2456);          // mode 00, ch C
    check_all("R2 stage only");
    send_word(16'hB000);          // copy, data/chan ignored
    check_all("R4 copy staged");
  endtask

  task automatic t_single;
    send_word(16'h4A01);
    check_all("R3 R10 ch A");
    send_word(16'h5B02);
    check_all("R3 R10 ch B");
    send_word(16'h6C03);
    check_all("R3 R10 ch C");
    send_word(16'h7D04);
    check_all("R1 R3 R10 ch D");
  endtask

  task automatic t_bcast;
    send_word(16'hCFFF);
    check_all("R5 full scale all");
    send_word(16'hF000);
    check_all("R5 zero all");
    send_word(16'hC800);
    check_all("R5 R9 mid all");
  endtask

  task automatic t_abort;
    send_bits({16'h0, 16'h0555}, 10);   // staged write cut short
    check_all("R7 short 10");
    send_bits({16'h0, 16'h5123}, 15);   // direct write, 15 bits
    check_all("R7 short 15");
    send_word(16'h8000);                // reveal input regs
    check_all("R7 inputs untouched");
  endtask

  task automatic t_extra;
    send_bits({12'h0, 16'h60A5, 4'hF}, 20);
    model(16'h60A5);
    check_all("R8 trailing bits ignored");
    send_word(16'h7321);
    check_all("R8 next frame");
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) begin
      in_m[k] = '0; dac_m[k] = '0; exp_cnt[k] = 0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_stage();
    t_single();
    t_bcast();
    t_abort();
    t_extra();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog (all reqs) actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule